// File: doc/BRIEF.md
# CPU-to-PCI Outbound Address Mapper with Posted Write Slots

This block takes outbound I/O requests from a processor core, each carrying a 34-bit CPU address, a byte-enable mask, a size code and (for writes) up to 32 bytes of data. It converts the address into a 32-bit PCI address and checks the request against the rules of its address space. It then hands the result to the PCI side as a valid/ready request stream. Address bit 33 picks the space. The sparse space drops the five low address bits and puts a 5-bit field from a configuration input in the top bits. The dense space passes the low 32 address bits through unchanged.

Requests that break their space's rules are accepted and dropped, and an error pulse reports them. Legal requests go into a two-slot queue. Writes are posted: the core can move on while up to two of them wait for the PCI side. A read enters only when the queue is empty, so it never overtakes an earlier write.

Top module: `pci_addr_map`

## Requirements
- R1: Address bit 33 low selects sparse space, whose PCI address is `{sparse_hi, req_addr[31:5]}`, with `sparse_hi` in bits 31:27.
- R2: Address bit 33 high selects dense space, whose PCI address equals `req_addr[31:0]`.
- R3: `req_len` codes a size of 2^len bytes (0 = 1 B … 5 = 32 B; 6 and 7 are always illegal). A sparse request is legal only when its size is 8 bytes or less. Its byte mask is not restricted.
- R4: A dense request is legal only when mask bits [size-1:0] are all set. A dense read is limited to 8 bytes and a dense write to 32 bytes.
- R5: An illegal request is still handshaken. `err_o` is high for exactly the one cycle after it is accepted, and nothing is emitted for it.
- R6: Up to two legal requests are held. While two are held, `req_ready` is low for a write.
- R7: A read is accepted only when no request is held. Requests leave in the order they were accepted.
- R8: The sparse high field is taken from `sparse_hi` in the cycle the request is accepted. Later changes do not affect it.
- R9: After reset, `out_valid` and `err_o` are low and `req_ready` is high. While `out_valid` is high and `out_ready` is low, every output field holds steady.
- R10: The write flag, size code, byte mask and data leave unchanged from the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sparse_hi | input | 5 | Upper PCI address field used by sparse space |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 34 | CPU address; bit 33 selects dense |
| req_len | input | 3 | Size code, 2^len bytes |
| req_mask | input | 32 | Byte enables |
| req_data | input | 256 | Write data |
| err_o | output | 1 | Illegal request rejected (one-cycle pulse) |
| out_valid | output | 1 | Translated request present |
| out_ready | input | 1 | PCI side takes the request |
| out_write | output | 1 | Write flag |
| out_addr | output | 32 | PCI address |
| out_len | output | 3 | Size code |
| out_mask | output | 32 | Byte enables |
| out_data | output | 256 | Write data |

## Verification
An accepted legal request shows at the output from the cycle right after the accepting edge, and `err_o` follows a rejection after the same single edge. The bench drives inputs and reads outputs at falling edges. After each handshake it samples at the next falling edge, exactly one register stage later. Back-pressure results are sampled at the falling edge just before the edge whose handshake they predict: `req_ready` low while slots are full, a read held off until the queue drains, and outputs held steady. Each drain step then advances one edge at a time.

// File: rtl/pam_pkg.sv
package pam_pkg;
  localparam int CPU_AW = 34;
  localparam int PCI_AW = 32;
  localparam int LEN_W  = 3;
  localparam int MASK_W = 32;
  localparam int DATA_W = 256;
  localparam int SHIFT  = 5;
  localparam int HI_W   = PCI_AW - (PCI_AW - SHIFT);
  localparam int SPARSE_MAX_LEN = 3;
  localparam int DREAD_MAX_LEN  = 3;
  localparam int DWRITE_MAX_LEN = 5;

  typedef struct packed {
    logic              write;
    logic [PCI_AW-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic [MASK_W-1:0] mask;
    logic [DATA_W-1:0] data;
  } pci_req_t;
endpackage

// File: rtl/pam_xlate.sv
module pam_xlate
  import pam_pkg::*;
(
  input  logic              write,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [MASK_W-1:0] mask,
  input  logic [HI_W-1:0]   hi_field,
  output logic [PCI_AW-1:0] pci_addr,
  output logic              legal
);
  logic              dense;
  logic [MASK_W-1:0] need;
  logic              full_mask;

  assign dense = cpu_addr[CPU_AW-1];

  always_comb begin
    for (int i = 0; i < MASK_W; i++)
      need[i] = (i < (1 << len));
  end
  assign full_mask = ((mask & need) == need);

  always_comb begin
    if (dense) begin
      pci_addr = cpu_addr[PCI_AW-1:0];
      if (write) legal = full_mask && (int'(len) <= DWRITE_MAX_LEN);
      else       legal = full_mask && (int'(len) <= DREAD_MAX_LEN);
    end else begin
      pci_addr = {hi_field, cpu_addr[PCI_AW-1:SHIFT]};
      legal    = (int'(len) <= SPARSE_MAX_LEN);
    end
  end
endmodule

// File: rtl/pam_queue.sv
module pam_queue
  import pam_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  pci_req_t         din,
  input  logic             pop,
  output pci_req_t         dout,
  output logic             empty,
  output logic             full
);
  pci_req_t          mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pci_addr_map.sv
module pci_addr_map
  import pam_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HI_W-1:0]   sparse_hi,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CPU_AW-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [MASK_W-1:0] req_mask,
  input  logic [DATA_W-1:0] req_data,
  output logic              err_o,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_write,
  output logic [PCI_AW-1:0] out_addr,
  output logic [LEN_W-1:0]  out_len,
  output logic [MASK_W-1:0] out_mask,
  output logic [DATA_W-1:0] out_data
);
  logic [PCI_AW-1:0] xl_addr;
  logic              xl_ok;
  logic              q_empty, q_full;
  logic              fire, push, pop;
  pci_req_t          q_in, q_out;

  pam_xlate u_xlate (
    .write(req_write), .cpu_addr(req_addr), .len(req_len), .mask(req_mask),
    .hi_field(sparse_hi), .pci_addr(xl_addr), .legal(xl_ok)
  );

  assign req_ready = req_write ? !q_full : q_empty;
  assign fire      = req_valid && req_ready;
  assign push      = fire && xl_ok;
  assign pop       = out_valid && out_ready;

  assign q_in = '{write: req_write, addr: xl_addr, len: req_len,
                  mask: req_mask, data: req_data};

  pam_queue #(.DEPTH(SLOTS)) u_queue (
    .clk(clk), .rst(rst), .push(push), .din(q_in), .pop(pop),
    .dout(q_out), .empty(q_empty), .full(q_full)
  );

  assign out_valid = !q_empty;
  assign out_write = q_out.write;
  assign out_addr  = q_out.addr;
  assign out_len   = q_out.len;
  assign out_mask  = q_out.mask;
  assign out_data  = q_out.data;

  always_ff @(posedge clk) begin
    if (rst) err_o <= 1'b0;
    else     err_o <= fire && !xl_ok;
  end
endmodule

// File: rtl/pam_checker.sv
module pam_checker
  import pam_pkg::*;
#(
  parameter int SLOTS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [HI_W-1:0]   sparse_hi,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [CPU_AW-1:0] req_addr,
  input logic              xl_ok,
  input logic              err_o,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PCI_AW-1:0] out_addr,
  input logic [MASK_W-1:0] out_mask,
  input logic [DATA_W-1:0] out_data
);
  int held;
  logic in_fire, out_fire;
  assign in_fire  = req_valid && req_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) held <= 0;
    else held <= held + ((in_fire && xl_ok) ? 1 : 0) - (out_fire ? 1 : 0);
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    held <= SLOTS);
  assert_write_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (req_write && held == SLOTS) |-> !req_ready);
  assert_read_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (in_fire && !req_write) |-> !out_valid);
  assert_reject_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(in_fire && !xl_ok));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_mask) && $stable(out_data)));
  assert_dense_R2: assert property (@(posedge clk) disable iff (rst)
    (in_fire && xl_ok && req_addr[CPU_AW-1] && held == 0)
      |=> out_addr == $past(req_addr[PCI_AW-1:0]));
  assert_sparse_R1: assert property (@(posedge clk) disable iff (rst)
    (in_fire && xl_ok && !req_addr[CPU_AW-1] && held == 0)
      |=> out_addr == {$past(sparse_hi), $past(req_addr[PCI_AW-1:SHIFT])});
endmodule

bind pci_addr_map pam_checker #(.SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst(rst), .sparse_hi(sparse_hi), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
  .xl_ok(xl_ok), .err_o(err_o), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_mask(out_mask), .out_data(out_data)
);

// File: tb/pci_addr_map_test.sv
module pci_addr_map_test;
  logic         clk = 0;
  logic         rst = 1;
  logic [4:0]   sparse_hi = '0;
  logic         req_valid = 0, req_write = 0, out_ready = 0;
  logic [33:0]  req_addr = '0;
  logic [2:0]   req_len = '0;
  logic [31:0]  req_mask = '0;
  logic [255:0] req_data = '0;
  logic         req_ready, err_o, out_valid, out_write;
  logic [31:0]  out_addr, out_mask;
  logic [2:0]   out_len;
  logic [255:0] out_data;
  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  pci_addr_map uut (
    .clk(clk), .rst(rst), .sparse_hi(sparse_hi), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_len(req_len), .req_mask(req_mask), .req_data(req_data),
    .err_o(err_o), .out_valid(out_valid), .out_ready(out_ready),
    .out_write(out_write), .out_addr(out_addr), .out_len(out_len),
    .out_mask(out_mask), .out_data(out_data)
  );

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic w, logic [33:0] a, logic [2:0] l, logic [31:0] m,
                       logic [255:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_len = l;
    req_mask = m; req_data = d;
  endtask

  // drive at a falling edge, wait for ready, finish at the falling edge after accept
  task automatic send(logic w, logic [33:0] a, logic [2:0] l, logic [31:0] m,
                      logic [255:0] d);
    drive(w, a, l, m, d);
    #0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    check("R9 reset out_valid", 256'(out_valid), 0);
    check("R9 reset err_o", 256'(err_o), 0);
    check("R9 reset ready", 256'(req_ready), 1);
  endtask

  task automatic t_sparse();
    logic [33:0] a = 34'h0_9234_5678;
    sparse_hi = 5'h15; out_ready = 0;
    send(0, a, 3'd2, 32'h3, '0);
    check("R1 sparse addr", 256'(out_addr), 256'({5'h15, a[31:5]}));
    check("R3 sparse masked read legal", 256'(err_o), 0);
    check("R10 mask through", 256'(out_mask), 256'(32'h3));
    out_ready = 1; @(negedge clk); out_ready = 0;
    check("R1 drained", 256'(out_valid), 0);
  endtask

  task automatic t_dense_write();
    logic [33:0] a = 34'h2_ABCD_EF40;
    logic [255:0] d = {8{32'hC0DE_0000}} ^ 256'h1234;
    send(1, a, 3'd5, 32'hFFFF_FFFF, d);
    check("R2 dense addr", 256'(out_addr), 256'(a[31:0]));
    check("R10 data", out_data, d);
    check("R10 write flag", 256'(out_write), 1);
    check("R10 len", 256'(out_len), 5);
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  task automatic t_rejects();
    send(1, 34'h2_0000_1000, 3'd3, 32'h0000_00F7, '0);
    check("R4 dense masked write err", 256'(err_o), 1);
    check("R5 nothing emitted", 256'(out_valid), 0);
    @(negedge clk);
    check("R5 err one cycle", 256'(err_o), 0);
    send(0, 34'h2_0000_2000, 3'd4, 32'hFFFF, '0);
    check("R4 dense 16B read err", 256'(err_o), 1);
    send(1, 34'h0_0000_3000, 3'd4, 32'hFFFF, '0);
    check("R3 sparse 16B err", 256'(err_o), 1);
    send(0, 34'h2_0000_4000, 3'd3, 32'hFF, '0);
    check("R4 dense 8B read legal", 256'(err_o), 0);
    check("R4 dense read emitted", 256'(out_valid), 1);
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  task automatic t_full_and_order();
    sparse_hi = 5'h0A;
    send(1, 34'h0_0000_0100, 3'd3, 32'hFF, 256'hA);
    sparse_hi = 5'h1F;
    send(1, 34'h2_0000_0200, 3'd3, 32'hFF, 256'hB);
    drive(1, 34'h2_0000_0300, 3'd3, 32'hFF, 256'hC);
    #0;
    check("R6 write stalled when full", 256'(req_ready), 0);
    drive(0, 34'h2_0000_0400, 3'd2, 32'hF, '0);
    #0;
    check("R7 read held while writes queued", 256'(req_ready), 0);
    @(negedge clk);
    check("R9 output held", 256'(out_addr), 256'({5'h0A, 27'h8}));
    check("R8 field sampled at accept", 256'(out_addr[31:27]), 256'(5'h0A));
    out_ready = 1;
    @(negedge clk);
    check("R7 order second", 256'(out_addr), 256'(32'h0000_0200));
    check("R7 read still held", 256'(req_ready), 0);
    @(negedge clk);
    check("R7 read ready after drain", 256'(req_ready), 1);
    check("R7 queue empty", 256'(out_valid), 0);
    out_ready = 0;
    @(negedge clk);
    req_valid = 0;
    check("R7 read emitted last", 256'(out_addr), 256'(32'h0000_0400));
    check("R10 read flag", 256'(out_write), 0);
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_sparse();
    t_dense_write();
    t_rejects();
    t_full_and_order();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule